// File: doc/BRIEF.md
# Prioritized Interrupt Request Tracker

This block keeps the interrupt state of one processor across 256 vectors. It holds a bitmap of pending requests, a bitmap of vectors in service, a task priority register and a processor priority derived from them. A request port marks one vector pending per cycle. A combinational offer output names the highest pending vector that may interrupt now. An accept strobe moves that offered vector into service. An end-of-interrupt strobe retires the highest vector in service.

Vectors in service are also kept on a nesting stack. The processor priority is formed from the stack top and the task priority, so delivery is gated by priority class (the upper four bits of a vector) rather than by bit position alone. Vectors 0 to 31 are reserved and can be recorded but are never offered or retired. A read port returns any bitmap word, the task priority or the processor priority.

Top module: `irq_prio_tracker`

## Requirements
- R1: A request for vector v sets bit v%32 of pending word v/32, readable on the cycle after the strobe with rd_sel_i = v/32 (0..7). This applies to any vector, including 0..31.
- R2: The offer is the highest pending vector in 32..255, and it is valid only when its class (vector[7:4]) is strictly above the class of the processor priority. When that highest vector is blocked, no lower pending vector is offered. Vectors 0..31 are never offered.
- R3: The processor priority equals the task priority when the task priority class is at least the class of the stack top. Otherwise it equals the stack-top vector with its low nibble cleared. An empty stack counts as top 0. It is read with rd_sel_i = 17.
- R4: A task priority write stores bits [7:0] of the write data, readable with rd_sel_i = 16 (zero-extended). The new value affects the processor priority and the offer on the next cycle.
- R5: Accept while an offer is valid clears that vector's pending bit, sets its in-service bit (rd_sel_i = 8 + v/32) and pushes it. Accept with no valid offer is ignored.
- R6: End-of-interrupt clears the highest set in-service bit among vectors 32..255 and pops the stack.
- R7: End-of-interrupt with an empty stack changes neither bitmap, and it raises the error flag.
- R8: Accept with the stack holding STK_DEPTH entries (and no pop in the same cycle) raises the error flag. The vector stays pending and the in-service bitmap is unchanged.
- R9: The error flag, once set, stays set until reset.
- R10: When a request and an accept of the same vector fall in one cycle, the vector ends both pending and in service.
- R11: When end-of-interrupt and accept fall in one cycle, the retire is applied first and the push second. This holds even when the stack is full.
- R12: After reset both bitmaps, the task priority and the processor priority are zero, no offer is valid and the error flag is low. Reads with rd_sel_i above 17 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set_i | input | 1 | Mark req_vec_i pending |
| req_vec_i | input | 8 | Vector to mark pending |
| accept_i | input | 1 | Take the offered vector into service |
| eoi_i | input | 1 | Retire the highest vector in service |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_wdata_i | input | 32 | Task priority write data (low 8 bits kept) |
| rd_sel_i | input | 5 | Read select: 0-7 pending words, 8-15 in-service words, 16 task priority, 17 processor priority |
| rd_data_o | output | 32 | Read data for rd_sel_i |
| offer_valid_o | output | 1 | An interrupt is offered |
| offer_vec_o | output | 8 | Offered vector |
| stk_err_o | output | 1 | Sticky nesting-stack error |

## Verification
The collisions that matter are a request landing in the same cycle as an accept of the same vector, and an end-of-interrupt landing in the same cycle as an accept. The latter case is driven once with a partly filled stack and once with a full one. The bench drives each pair in a single cycle against a small stack depth. It then compares every bitmap word, both priorities, the offer and the error flag with a reference model that applies retire, then push, then request. An overflow run fills the stack to check that a refused push leaves the vector pending.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W     = 8;
  localparam int CLS_W     = 4;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int NUM_VEC   = WORD_W * NUM_WORDS;
  localparam int RSVD_VEC  = 32;
  localparam int SEL_W     = 5;
  localparam int SEL_TPR   = 2 * NUM_WORDS;
  localparam int SEL_PPR   = 2 * NUM_WORDS + 1;

  function automatic logic [CLS_W-1:0] vec_class(input logic [VEC_W-1:0] v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  function automatic logic [VEC_W-1:0] derive_ppr(input logic [VEC_W-1:0] tpr,
                                                  input logic [VEC_W-1:0] top_vec);
    if (vec_class(tpr) >= vec_class(top_vec)) return tpr;
    return {vec_class(top_vec), {(VEC_W-CLS_W){1'b0}}};
  endfunction
endpackage

// File: rtl/irq_msb_find.sv
module irq_msb_find #(
  parameter int W     = 256,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     bits_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < W; i++) begin
      if (bits_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int DEPTH = 16,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req_i,
  input  logic [VEC_W-1:0] push_vec_i,
  input  logic             pop_req_i,
  output logic             push_done_o,
  output logic             pop_done_o,
  output logic [VEC_W-1:0] top_vec_o,
  output logic             err_o
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [PTR_W-1:0] top_q, top_d, top_after_pop, top_m1;
  logic [VEC_W-1:0] ent_q [DEPTH];
  logic             err_q;

  always_comb begin
    pop_done_o    = pop_req_i && (top_q != '0);
    top_after_pop = top_q - PTR_W'(pop_done_o);
    push_done_o   = push_req_i && (top_after_pop != PTR_W'(DEPTH));
    top_d         = top_after_pop + PTR_W'(push_done_o);
    top_m1        = top_q - PTR_W'(1);
    top_vec_o     = (top_q == '0) ? '0 : ent_q[top_m1[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      err_q <= 1'b0;
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
    end else begin
      top_q <= top_d;
      err_q <= err_q | (pop_req_i && !pop_done_o) | (push_req_i && !push_done_o);
      if (push_done_o) ent_q[top_after_pop[IDX_W-1:0]] <= push_vec_i;
    end
  end

  assign err_o = err_q;

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_underflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req_i && top_q == '0) |=> err_q);
  assert_overflow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req_i && !pop_req_i && top_q == PTR_W'(DEPTH)) |=> ($stable(top_q) && err_q));
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker
  import irq_pkg::*;
#(
  parameter int STK_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_set_i,
  input  logic [VEC_W-1:0]  req_vec_i,
  input  logic              accept_i,
  input  logic              eoi_i,
  input  logic              tpr_we_i,
  input  logic [31:0]       tpr_wdata_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [31:0]       rd_data_o,
  output logic              offer_valid_o,
  output logic [VEC_W-1:0]  offer_vec_o,
  output logic              stk_err_o
);
  localparam int WSEL_W = $clog2(NUM_WORDS);

  logic [NUM_VEC-1:0] irr_q, isr_q, irr_d, isr_d;
  logic [NUM_VEC-1:0] irr_scan, isr_scan;
  logic [NUM_VEC-1:0] acc_mask, eoi_mask, set_mask;
  logic [VEC_W-1:0]   tpr_q, ppr_w, top_vec, irr_idx, isr_idx;
  logic               irr_found, isr_found;
  logic               push_req, push_done, pop_done;
  logic [WSEL_W-1:0]  wsel;

  // Reserved vectors are masked out of both searches.
  always_comb begin
    irr_scan = irr_q;
    isr_scan = isr_q;
    irr_scan[RSVD_VEC-1:0] = '0;
    isr_scan[RSVD_VEC-1:0] = '0;
  end

  irq_msb_find #(.W(NUM_VEC), .IDX_W(VEC_W)) u_irr_find (
    .bits_i(irr_scan), .found_o(irr_found), .idx_o(irr_idx));
  irq_msb_find #(.W(NUM_VEC), .IDX_W(VEC_W)) u_isr_find (
    .bits_i(isr_scan), .found_o(isr_found), .idx_o(isr_idx));

  irq_nest_stack #(.DEPTH(STK_DEPTH), .VEC_W(VEC_W)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push_req_i(push_req), .push_vec_i(irr_idx), .pop_req_i(eoi_i),
    .push_done_o(push_done), .pop_done_o(pop_done),
    .top_vec_o(top_vec), .err_o(stk_err_o));

  always_comb begin
    ppr_w         = derive_ppr(tpr_q, top_vec);
    offer_valid_o = irr_found && (vec_class(irr_idx) > vec_class(ppr_w));
    offer_vec_o   = irr_idx;
    push_req      = accept_i && offer_valid_o;
    acc_mask      = push_done ? (NUM_VEC'(1) << irr_idx) : '0;
    eoi_mask      = (pop_done && isr_found) ? (NUM_VEC'(1) << isr_idx) : '0;
    set_mask      = req_set_i ? (NUM_VEC'(1) << req_vec_i) : '0;
    // retire, then push, then new request
    isr_d         = (isr_q & ~eoi_mask) | acc_mask;
    irr_d         = (irr_q & ~acc_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tpr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      if (tpr_we_i) tpr_q <= tpr_wdata_i[VEC_W-1:0];
    end
  end

  always_comb begin
    wsel = rd_sel_i[WSEL_W-1:0];
    if (int'(rd_sel_i) < NUM_WORDS)          rd_data_o = irr_q[wsel*WORD_W +: WORD_W];
    else if (int'(rd_sel_i) < 2 * NUM_WORDS) rd_data_o = isr_q[wsel*WORD_W +: WORD_W];
    else if (int'(rd_sel_i) == SEL_TPR)      rd_data_o = 32'(tpr_q);
    else if (int'(rd_sel_i) == SEL_PPR)      rd_data_o = 32'(ppr_w);
    else                                     rd_data_o = '0;
  end

  assert_no_low_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid_o |-> (int'(offer_vec_o) >= RSVD_VEC && irr_q[offer_vec_o]));
  assert_tpr_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_we_i |=> (tpr_q == $past(tpr_wdata_i[VEC_W-1:0])));
  assert_accept_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |=> isr_q[$past(offer_vec_o)]);
  assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_done && isr_found) |=> !isr_q[$past(isr_idx)]);
  assert_reraise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_done && req_set_i && req_vec_i == offer_vec_o) |=> irr_q[$past(offer_vec_o)]);
endmodule

// File: tb/irq_prio_tracker_tb.sv
`timescale 1ns/10ps
module irq_prio_tracker_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_set_i = 1'b0;
  logic [7:0]  req_vec_i = '0;
  logic        accept_i = 1'b0;
  logic        eoi_i = 1'b0;
  logic        tpr_we_i = 1'b0;
  logic [31:0] tpr_wdata_i = '0;
  logic [4:0]  rd_sel_i = '0;
  logic [31:0] rd_data_o;
  logic        offer_valid_o;
  logic [7:0]  offer_vec_o;
  logic        stk_err_o;

  int checks = 0;
  int errors = 0;

  logic [255:0] irr_m, isr_m;
  logic [7:0]   tpr_m;
  logic [7:0]   stk_m [0:DEPTH];
  int           top_m;
  bit           err_m;

  always #2 clk = ~clk;

  irq_prio_tracker #(.STK_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_set_i(req_set_i), .req_vec_i(req_vec_i),
    .accept_i(accept_i), .eoi_i(eoi_i), .tpr_we_i(tpr_we_i), .tpr_wdata_i(tpr_wdata_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .offer_valid_o(offer_valid_o),
    .offer_vec_o(offer_vec_o), .stk_err_o(stk_err_o));

  function automatic int m_ppr();
    int t = tpr_m;
    int s = stk_m[top_m];
    if ((t / 16) >= (s / 16)) return t;
    return (s / 16) * 16;
  endfunction

  function automatic int m_offer(); // -1 when none
    for (int v = 255; v >= 32; v--)
      if (irr_m[v]) return ((v / 16) > (m_ppr() / 16)) ? v : -1;
    return -1;
  endfunction

  task automatic model_reset();
    irr_m = '0; isr_m = '0; tpr_m = '0; top_m = 0; err_m = 1'b0;
    for (int k = 0; k <= DEPTH; k++) stk_m[k] = '0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    int ov = m_offer();
    logic [31:0] exp;
    chk({tag, " offer_valid"}, 32'(offer_valid_o), 32'(ov >= 0));
    if (ov >= 0) chk({tag, " offer_vec"}, 32'(offer_vec_o), 32'(ov));
    chk({tag, " stk_err"}, 32'(stk_err_o), 32'(err_m));
    for (int sel = 0; sel < 19; sel++) begin
      rd_sel_i = 5'(sel);
      #0.04;
      if (sel < 8)       exp = irr_m[sel*32 +: 32];
      else if (sel < 16) exp = isr_m[(sel-8)*32 +: 32];
      else if (sel == 16) exp = 32'(tpr_m);
      else if (sel == 17) exp = 32'(m_ppr());
      else exp = '0;
      chk({tag, " readback"}, rd_data_o, exp);
    end
  endtask

  task automatic drive(bit s, int sv, bit a, bit e, bit tw, logic [31:0] td);
    int ov;
    @(negedge clk);
    ov = m_offer();
    req_set_i = s; req_vec_i = 8'(sv); accept_i = a; eoi_i = e;
    tpr_we_i = tw; tpr_wdata_i = td;
    @(posedge clk);
    if (e) begin
      if (top_m == 0) err_m = 1'b1;
      else begin
        for (int v = 255; v >= 32; v--)
          if (isr_m[v]) begin isr_m[v] = 1'b0; break; end
        top_m--;
      end
    end
    if (a && ov >= 0) begin
      if (top_m == DEPTH) err_m = 1'b1;
      else begin
        irr_m[ov] = 1'b0; isr_m[ov] = 1'b1; top_m++; stk_m[top_m] = 8'(ov);
      end
    end
    if (s) irr_m[sv] = 1'b1;
    if (tw) tpr_m = td[7:0];
    @(negedge clk);
    req_set_i = 0; accept_i = 0; eoi_i = 0; tpr_we_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check_all("R12 reset");

    // Sweep every vector through request, accept, retire
    for (int v = 0; v < 256; v++) begin
      drive(1, v, 0, 0, 0, 0); check_all("R1 request");
      if (v >= 32) begin
        drive(0, 0, 1, 0, 0, 0); check_all("R5 accept");
        drive(0, 0, 0, 1, 0, 0); check_all("R6 eoi");
      end
    end
    // only reserved vectors pending: accept ignored
    drive(0, 0, 1, 0, 0, 0); check_all("R5 accept without offer");

    // Task priority sweep against one pending vector
    drive(1, 8'h85, 0, 0, 0, 0);
    for (int t = 0; t < 256; t += 7) begin
      drive(0, 0, 0, 0, 1, {24'hA5C3E1, 8'(t)}); check_all("R4 tpr write");
    end
    drive(0, 0, 0, 0, 1, 32'hFFFF_FF00); check_all("R3 tpr zero");
    drive(0, 0, 1, 0, 0, 0); check_all("R3 ppr from stack");
    drive(0, 0, 0, 0, 1, 32'h93); check_all("R3 tpr class higher");
    drive(0, 0, 0, 0, 1, 32'h7F); check_all("R3 stack class higher");
    drive(0, 0, 0, 0, 1, 32'h80); check_all("R3 equal class");
    drive(0, 0, 0, 0, 1, 32'h00);
    drive(0, 0, 0, 1, 0, 0); check_all("R6 eoi");

    // Nesting and class blocking
    drive(1, 8'h60, 0, 0, 0, 0); drive(0, 0, 1, 0, 0, 0);
    drive(1, 8'h50, 0, 0, 0, 0); drive(1, 8'h4F, 0, 0, 0, 0); check_all("R2 blocked");
    drive(1, 8'h6A, 0, 0, 0, 0); check_all("R2 same class blocked");
    drive(1, 8'h70, 0, 0, 0, 0); check_all("R2 higher offered");
    drive(0, 0, 1, 0, 0, 0); check_all("R5 nested accept");
    drive(0, 0, 0, 1, 0, 0); check_all("R6 pop nested");
    drive(0, 0, 0, 1, 0, 0); check_all("R6 pop outer");
    for (int k = 0; k < 3; k++) begin
      drive(0, 0, 1, 0, 0, 0); check_all("R5 drain accept");
      drive(0, 0, 0, 1, 0, 0); check_all("R6 drain eoi");
    end

    // Request and accept of the same vector in one cycle
    drive(1, 8'hA0, 0, 0, 0, 0);
    drive(1, 8'hA0, 1, 0, 0, 0); check_all("R10 re-raise");
    drive(0, 0, 0, 1, 0, 0); check_all("R10 re-offered");
    drive(0, 0, 1, 0, 0, 0); drive(0, 0, 0, 1, 0, 0); check_all("R10 cleared");

    // Retire and accept in one cycle
    drive(1, 8'h40, 0, 0, 0, 0); drive(0, 0, 1, 0, 0, 0);
    drive(1, 8'h90, 0, 0, 0, 0);
    drive(0, 0, 1, 1, 0, 0); check_all("R11 eoi with accept");
    drive(0, 0, 0, 1, 0, 0); check_all("R11 after");

    // Overflow on a full stack
    drive(1, 8'h30, 0, 0, 0, 0); drive(0, 0, 1, 0, 0, 0);
    drive(1, 8'h41, 0, 0, 0, 0); drive(0, 0, 1, 0, 0, 0);
    drive(1, 8'h52, 0, 0, 0, 0); drive(0, 0, 1, 0, 0, 0);
    drive(1, 8'h63, 0, 0, 0, 0); drive(0, 0, 1, 0, 0, 0);
    drive(1, 8'h74, 0, 0, 0, 0); check_all("R8 full stack offer");
    drive(0, 0, 1, 0, 0, 0); check_all("R8 overflow refused");
    drive(0, 0, 1, 1, 0, 0); check_all("R11 full stack eoi with accept");
    for (int k = 0; k < 4; k++) begin
      drive(0, 0, 0, 1, 0, 0); check_all("R9 sticky");
    end

    // Underflow
    do_reset();
    check_all("R12 reset again");
    drive(1, 8'h05, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 0); check_all("R7 eoi on empty");
    drive(1, 8'h33, 0, 0, 0, 0); drive(0, 0, 1, 0, 0, 0); check_all("R9 flag held");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule